// File: doc/BRIEF.md
# Multi-Channel Down-Counting Timer

A memory-mapped timer with a parameterised number of channels (two or three), each a 32-bit down-counter. One shared run register gives every channel its own start bit. Each channel has three registers. The first holds the constant that the counter reloads from. The second is the live counter, which software can write. The third is a 16-bit control word that selects the prescaler, holds the sticky underflow flag and enables the interrupt.

While a channel runs, its counter falls by one on every prescaled tick. The tick comes from the block clock divided by 4, 16, 64, 256 or 1024. When a tick arrives with the counter at zero, the counter reloads from the constant, the flag sets, and the channel's interrupt line goes high if it is enabled. Software writes the counter while the channel is stopped to set the time to the first underflow. It then sets the run bit and clears the flag from its interrupt handler.

Access is through a single-cycle register port with per-byte write enables. Read data is combinational from the address.

Top module: `dtimer_unit`

## Requirements
- R1: Register map, all addresses word-aligned. The run register is at byte offset 0x04, in byte lane 0. Channel n's registers start at 0x08 + 12·n, in this order: the reload constant (+0), the counter (+4) and the control word (+8). A write changes only the bytes whose byte enable is set.
- R2: After reset every register reads zero, every channel is stopped and every interrupt output is low.
- R3: Run register bit n starts channel n when 1 and stops it when 0. Bits at or above the channel count read as zero. Channels count independently of each other.
- R4: A stopped channel holds its counter. A counter write, running or stopped, sets the value that is read back.
- R5: A running channel decrements once per prescaled tick. Control bits [2:0] select the tick period: 4, 16, 64, 256 or 1024 clocks for codes 0 to 4, and codes 5 to 7 act as code 4. The first decrement after the run bit is written becomes visible one full period after that write.
- R6: A tick that arrives with the counter at zero loads the reload constant and sets the underflow flag, which is control bit 8.
- R7: The underflow flag stays set until a control write with byte lane 1 enabled and bit 8 equal to 0. Writing 1 to bit 8 leaves the flag unchanged. A new underflow in the same cycle as a clearing write wins.
- R8: A channel's interrupt output equals its flag AND its enable bit (control bit 5). The output stays high until the flag is cleared.
- R9: Stopping a channel resets its prescaler, so after a restart the first tick comes one full period after the restart.
- R10: Reads of unmapped or unaligned addresses return zero, and writes to them change nothing. Unused control bits read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; prescalers divide this |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access strobe for this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW (8) | Byte address |
| bus_be | input | 4 | Byte enables for writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational; zero when idle or unmapped |
| irq_o | output | NCH (3) | Per-channel interrupt request |

## Verification
The checker watches four things on every cycle:
- a stopped counter holds its value unless software writes it;
- an underflow tick always produces the reload value and a set flag in the next cycle;
- the flag and a raised interrupt persist until a control write;
- no tick can follow directly on a stopped cycle.

Only the bench scenarios can show the rest, because it depends on exact timing and layout: the exact period for each prescaler code, the cycle of the first decrement after start and after a restart, byte-lane merging, the address map and the zero returned for holes.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int TW     = 32;          // counter width
    localparam int TB     = TW / 8;      // byte lanes
    localparam int PSW    = 10;          // prescaler width (max divide 1024)
    localparam int CTRLW  = 16;
    localparam int OFS_RUN  = 4;
    localparam int OFS_CH0  = 8;
    localparam int CH_PITCH = 12;

    typedef struct packed {
        logic [TW-1:0] reload;
        logic [TW-1:0] cnt;
        logic [2:0]    ps;
        logic          ie;
        logic          flag;
    } chan_t;

    function automatic logic [PSW-1:0] ps_limit(input logic [2:0] code);
        case (code)
            3'd0:    ps_limit = PSW'(3);
            3'd1:    ps_limit = PSW'(15);
            3'd2:    ps_limit = PSW'(63);
            3'd3:    ps_limit = PSW'(255);
            default: ps_limit = PSW'(1023);
        endcase
    endfunction

    function automatic logic [TW-1:0] be_merge(input logic [TW-1:0] old_v,
                                               input logic [TW-1:0] new_v,
                                               input logic [TB-1:0] be);
        logic [TW-1:0] r;
        r = old_v;
        for (int b = 0; b < TB; b++)
            if (be[b]) r[b*8 +: 8] = new_v[b*8 +: 8];
        return r;
    endfunction
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
    import tmr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [2:0] sel,
    output logic       tick
);
    logic [PSW-1:0] div_d, div_q;
    logic [PSW-1:0] lim;

    always_comb begin
        lim  = ps_limit(sel);
        tick = 1'b0;
        if (!run) begin
            div_d = '0;
        end else if (div_q >= lim) begin
            div_d = '0;
            tick  = 1'b1;
        end else begin
            div_d = div_q + PSW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             wr_reload,
    input  logic             wr_cnt,
    input  logic             wr_ctrl,
    input  logic [TB-1:0]    be,
    input  logic [TW-1:0]    wdata,
    output logic [TW-1:0]    reload_o,
    output logic [TW-1:0]    cnt_o,
    output logic [CTRLW-1:0] ctrl_o,
    output logic             tick_o,
    output logic             flag_o,
    output logic             irq_o
);
    chan_t s_d, s_q;
    logic  tick;
    logic  under;

    tmr_prescaler u_ps (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (run),
        .sel  (s_q.ps),
        .tick (tick)
    );

    always_comb begin
        s_d   = s_q;
        under = 1'b0;
        if (wr_reload) s_d.reload = be_merge(s_q.reload, wdata, be);
        if (wr_cnt) begin
            s_d.cnt = be_merge(s_q.cnt, wdata, be);
        end else if (tick) begin
            if (s_q.cnt == '0) begin
                s_d.cnt = s_q.reload;
                under   = 1'b1;
            end else begin
                s_d.cnt = s_q.cnt - TW'(1);
            end
        end
        if (wr_ctrl) begin
            if (be[0]) begin
                s_d.ps = wdata[2:0];
                s_d.ie = wdata[5];
            end
            if (be[1] && !wdata[8]) s_d.flag = 1'b0;
        end
        if (under) s_d.flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign reload_o = s_q.reload;
    assign cnt_o    = s_q.cnt;
    assign ctrl_o   = {7'b0, s_q.flag, 2'b0, s_q.ie, 2'b0, s_q.ps};
    assign tick_o   = tick;
    assign flag_o   = s_q.flag;
    assign irq_o    = s_q.flag & s_q.ie;
endmodule

// File: rtl/dtimer_unit.sv
module dtimer_unit
    import tmr_pkg::*;
#(
    parameter int NCH = 3,
    parameter int AW  = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_sel,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [TB-1:0] bus_be,
    input  logic [TW-1:0] bus_wdata,
    output logic [TW-1:0] bus_rdata,
    output logic [NCH-1:0] irq_o
);
    logic [NCH-1:0] run_d, run_q;
    logic           wr_en, rd_en, run_hit;

    logic [NCH-1:0]           hit_rl, hit_cn, hit_ct;
    logic [NCH-1:0]           cnt_wr, ctrl_wr, ch_tick, ch_flag;
    logic [NCH-1:0][TW-1:0]   ch_reload, ch_cnt;
    logic [NCH-1:0][CTRLW-1:0] ch_ctrl;

    assign wr_en   = bus_sel & bus_wr;
    assign rd_en   = bus_sel & ~bus_wr;
    assign run_hit = (bus_addr == AW'(OFS_RUN));

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        localparam int BASE = OFS_CH0 + CH_PITCH * i;
        assign hit_rl[i]  = (bus_addr == AW'(BASE));
        assign hit_cn[i]  = (bus_addr == AW'(BASE + 4));
        assign hit_ct[i]  = (bus_addr == AW'(BASE + 8));
        assign cnt_wr[i]  = wr_en & hit_cn[i];
        assign ctrl_wr[i] = wr_en & hit_ct[i];

        tmr_channel u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .run      (run_q[i]),
            .wr_reload(wr_en & hit_rl[i]),
            .wr_cnt   (cnt_wr[i]),
            .wr_ctrl  (ctrl_wr[i]),
            .be       (bus_be),
            .wdata    (bus_wdata),
            .reload_o (ch_reload[i]),
            .cnt_o    (ch_cnt[i]),
            .ctrl_o   (ch_ctrl[i]),
            .tick_o   (ch_tick[i]),
            .flag_o   (ch_flag[i]),
            .irq_o    (irq_o[i])
        );
    end

    always_comb begin
        run_d = run_q;
        if (wr_en && run_hit && bus_be[0]) run_d = bus_wdata[NCH-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) run_q <= '0;
        else        run_q <= run_d;
    end

    always_comb begin
        bus_rdata = '0;
        if (rd_en) begin
            if (run_hit) bus_rdata[NCH-1:0] = run_q;
            for (int i = 0; i < NCH; i++) begin
                if (hit_rl[i]) bus_rdata = ch_reload[i];
                if (hit_cn[i]) bus_rdata = ch_cnt[i];
                if (hit_ct[i]) bus_rdata = {{(TW-CTRLW){1'b0}}, ch_ctrl[i]};
            end
        end
    end
endmodule

// File: rtl/dtimer_unit_chk.sv
module dtimer_unit_chk
    import tmr_pkg::*;
#(
    parameter int NCH = 3
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NCH-1:0]       run,
    input logic [NCH-1:0]       tick,
    input logic [NCH-1:0]       flag,
    input logic [NCH-1:0]       cnt_wr,
    input logic [NCH-1:0]       ctrl_wr,
    input logic [NCH-1:0]       irq,
    input logic [NCH-1:0][TW-1:0] cnt,
    input logic [NCH-1:0][TW-1:0] reload
);
    for (genvar i = 0; i < NCH; i++) begin : g_a
        a_r4_stopped_holds: assert property (@(posedge clk) disable iff (!rst_n)
            (!run[i] && !cnt_wr[i]) |=> cnt[i] == $past(cnt[i]));
        a_r6_reload_on_underflow: assert property (@(posedge clk) disable iff (!rst_n)
            (tick[i] && cnt[i] == '0 && !cnt_wr[i]) |=> (cnt[i] == $past(reload[i]) && flag[i]));
        a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            (flag[i] && !ctrl_wr[i]) |=> flag[i]);
        a_r8_irq_held: assert property (@(posedge clk) disable iff (!rst_n)
            (irq[i] && !ctrl_wr[i]) |=> irq[i]);
        a_r9_no_tick_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
            !run[i] |=> !tick[i]);
    end
endmodule

bind dtimer_unit dtimer_unit_chk #(.NCH(NCH)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (run_q),
    .tick   (ch_tick),
    .flag   (ch_flag),
    .cnt_wr (cnt_wr),
    .ctrl_wr(ctrl_wr),
    .irq    (irq_o),
    .cnt    (ch_cnt),
    .reload (ch_reload)
);

// File: tb/sim_dtimer_unit.sv
`timescale 1ns/1ps
module sim_dtimer_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [2:0]  irq_o;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;   // 50 MHz

    dtimer_unit #(.NCH(3), .AW(8)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_o(irq_o)
    );

    // {addr, be, wdata, expected readback}
    localparam int NV = 10;
    localparam logic [75:0] VEC [NV] = '{
        {8'h08, 4'hF, 32'h1234_5678, 32'h1234_5678},  // R1 full reload0
        {8'h0C, 4'h3, 32'hAABB_CCDD, 32'h0000_CCDD},  // R1 lanes 0-1 only
        {8'h10, 4'hF, 32'hFFFF_FF25, 32'h0000_0025},  // R7 R10 bit8=1 keeps flag 0
        {8'h14, 4'h8, 32'hA500_0000, 32'hA500_0000},  // R1 lane 3 only
        {8'h28, 4'h2, 32'h0000_0123, 32'h0000_0000},  // R1 ctrl2 lane 1 only
        {8'h00, 4'hF, 32'hFFFF_FFFF, 32'h0000_0000},  // R10 hole
        {8'h2C, 4'hF, 32'hFFFF_FFFF, 32'h0000_0000},  // R10 past last channel
        {8'h09, 4'hF, 32'hFFFF_FFFF, 32'h0000_0000},  // R10 unaligned
        {8'h04, 4'hF, 32'h0000_00FF, 32'h0000_0007},  // R3 upper run bits read 0
        {8'h04, 4'h1, 32'h0000_0000, 32'h0000_0000}   // R3 stop all
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // called at a negedge, returns at the next negedge
    task automatic wr(input logic [7:0] a, input logic [3:0] be, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_be = be; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic waitn(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 reset state
        rd(8'h04, v); chk("R2 run reg", v, 32'h0);
        rd(8'h08, v); chk("R2 reload0", v, 32'h0);
        rd(8'h0C, v); chk("R2 count0", v, 32'h0);
        rd(8'h10, v); chk("R2 ctrl0", v, 32'h0);
        rd(8'h28, v); chk("R2 ctrl2", v, 32'h0);
        chk("R2 irq", {29'b0, irq_o}, 32'h0);

        // vector table
        for (int k = 0; k < NV; k++) begin
            wr(VEC[k][75:68], VEC[k][67:64], VEC[k][63:32]);
            rd(VEC[k][75:68], v);
            chk($sformatf("R1/R3/R10 vec%0d", k), v, VEC[k][31:0]);
        end
        rd(8'h08, v); chk("R10 reload0 untouched by unaligned write", v, 32'h1234_5678);

        // R5 R6 R8: ch0 reload 5, count 2, div 4, irq enabled
        wr(8'h08, 4'hF, 32'd5);
        wr(8'h0C, 4'hF, 32'd2);
        wr(8'h10, 4'hF, 32'h20);
        wr(8'h04, 4'h1, 32'h1);
        waitn(11);
        rd(8'h0C, v); chk("R5 count0 before underflow", v, 32'd0);
        chk("R8 irq0 low before underflow", {31'b0, irq_o[0]}, 32'h0);
        waitn(1);
        rd(8'h0C, v); chk("R6 count0 reloaded", v, 32'd5);
        rd(8'h10, v); chk("R6 flag set", v, 32'h120);
        chk("R8 irq0 high", {31'b0, irq_o[0]}, 32'h1);
        waitn(4);
        rd(8'h0C, v); chk("R5 count0 after one period", v, 32'd4);
        wr(8'h04, 4'h1, 32'h0);
        waitn(8);
        rd(8'h0C, v); chk("R4 stopped count holds", v, 32'd4);
        wr(8'h10, 4'h3, 32'h120);
        rd(8'h10, v); chk("R7 writing 1 keeps flag", v, 32'h120);
        chk("R8 irq0 stays high", {31'b0, irq_o[0]}, 32'h1);
        wr(8'h10, 4'h3, 32'h020);
        rd(8'h10, v); chk("R7 flag cleared", v, 32'h020);
        chk("R8 irq0 drops", {31'b0, irq_o[0]}, 32'h0);
        wr(8'h0C, 4'hF, 32'h33);
        rd(8'h0C, v); chk("R4 count write", v, 32'h33);

        // R9 prescaler restart
        wr(8'h0C, 4'hF, 32'd10);
        wr(8'h04, 4'h1, 32'h1);
        waitn(2);
        wr(8'h04, 4'h1, 32'h0);
        wr(8'h04, 4'h1, 32'h1);
        waitn(3);
        rd(8'h0C, v); chk("R9 no early tick after restart", v, 32'd10);
        waitn(1);
        rd(8'h0C, v); chk("R9 tick one period after restart", v, 32'd9);
        wr(8'h04, 4'h1, 32'h0);
        wr(8'h0C, 4'hF, 32'h33);

        // R6 R8 R3: ch1 div 16, interrupt disabled
        wr(8'h14, 4'hF, 32'd7);
        wr(8'h18, 4'hF, 32'd0);
        wr(8'h1C, 4'hF, 32'h001);
        wr(8'h04, 4'h1, 32'h2);
        waitn(15);
        rd(8'h18, v); chk("R5 count1 before first tick", v, 32'd0);
        waitn(1);
        rd(8'h18, v); chk("R6 count1 reloaded", v, 32'd7);
        rd(8'h1C, v); chk("R6 flag1 set", v, 32'h101);
        chk("R8 irq1 masked", {29'b0, irq_o}, 32'h0);
        rd(8'h0C, v); chk("R3 ch0 unaffected", v, 32'h33);
        wr(8'h04, 4'h1, 32'h0);

        // R5 divide by 1024 on ch2
        wr(8'h24, 4'hF, 32'd1);
        wr(8'h28, 4'hF, 32'h004);
        wr(8'h04, 4'h1, 32'h4);
        waitn(1023);
        rd(8'h24, v); chk("R5 div1024 not yet", v, 32'd1);
        waitn(1);
        rd(8'h24, v); chk("R5 div1024 tick", v, 32'd0);
        wr(8'h04, 4'h1, 32'h0);

        summary();
        $finish;
    end
endmodule